// File: doc/BRIEF.md
# HDLC Frame Transmitter with Tagged Transmit Queue

This block turns a queue of bytes into a bit-serial HDLC line stream, one line bit per clock. Each byte pushed into the internal transmit queue carries two tag bits: one marks the last byte of a packet and one requests that the packet be aborted. Because the tags travel with the bytes, several complete packets can wait in the queue at once.

For each packet the block sends an opening flag, then the payload with zero insertion, then a CRC-16 frame check sequence, then a closing flag. A byte tagged for abort is replaced on the line by a run of ones, and no check sequence is sent. When the queue is empty, the line carries either continuous ones or back-to-back flags, chosen by a select input. The tags are armed through two one-shot request inputs that apply to the next accepted queue write only. Clearing the enable lets the packet in progress finish before the line goes quiet. If the queue runs dry in the middle of a packet, the packet is aborted and an underrun pulse is raised.

Top module: `hdlc_tx_tagged`

## Requirements
- R1: After reset, `tx_bit` is 1, `fifo_full` is 0, and both `eop_armed` and `abort_armed` are 0.
- R2: While `tx_en` is 0 and no packet is in progress, `tx_bit` stays 1 and queued bytes are held. Raising `tx_en` starts sending them.
- R3: Clearing `tx_en` during a packet does not cut the packet short. The packet completes with a valid check sequence and a closing flag.
- R4: With an empty queue and `tx_en` = 1, `fill_sel` = 0 gives continuous ones and `fill_sel` = 1 gives repeated flags 0x7E.
- R5: A packet is sent as flag 0x7E, then the payload bytes in queue order, then the check sequence, then flag 0x7E. Every byte goes least significant bit first. Packets queued back to back are each sent as a separate frame.
- R6: The check sequence is CRC-16 with reflected polynomial 0x8408 and initial value 0xFFFF, computed over the payload. It is complemented and sent low byte first.
- R7: Within payload and check sequence, a 0 is inserted after every five consecutive 1s. Flags are never stuffed.
- R8: A byte tagged for abort is not sent. In its place the line carries at least seven consecutive 1s, and no check sequence follows. Later packets in the queue are sent normally.
- R9: A pulse on `arm_eop` or `arm_abort` sets `eop_armed` or `abort_armed`. The armed tag is attached to the next accepted write and is then cleared. A request pulse in the same cycle as a write applies to that write.
- R10: If the queue is empty when the next payload byte of an open packet is needed, the packet is aborted as in R8 and `underrun` pulses high for one cycle.
- R11: The queue holds `DEPTH` entries. `fifo_full` is 1 when it is full, and a write while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmitter enable |
| fill_sel | input | 1 | Empty-queue pattern: 0 ones, 1 flags |
| arm_eop | input | 1 | One-shot request: tag next write as end of packet |
| arm_abort | input | 1 | One-shot request: tag next write as abort |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Byte to queue |
| fifo_full | output | 1 | Queue is full |
| eop_armed | output | 1 | End-of-packet tag waiting for a write |
| abort_armed | output | 1 | Abort tag waiting for a write |
| tx_bit | output | 1 | Serial line output |
| underrun | output | 1 | One-cycle pulse when a packet is aborted for lack of data |

## Verification
The embedded assertions check properties that hold on every cycle. The zero-insertion run length never exceeds five inside stuffed fields. An end-of-packet byte is always followed by the check sequence. A packet in progress never drops straight to the disabled state. Tags are always cleared by an accepted write. A full queue refuses writes. An underrun pulse coincides only with an abort.

Some behaviour only the bench's scenarios can show. The bench runs an independent line receiver that removes stuffed zeros, finds flags and aborts, and verifies each recovered frame's payload and check sequence. This covers correct frame content, idle pattern selection, queuing of several packets, the effect of disabling mid-packet, and data held while disabled.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    typedef enum logic [2:0] {
        U_OFF, U_IDLE, U_OPEN, U_DATA, U_FCSL, U_FCSH, U_CLOSE, U_ABORT
    } unit_e;

    typedef struct packed {
        logic       abort;
        logic       eop;
        logic [7:0] data;
    } entry_t;

    localparam logic [7:0]  FLAG_BYTE = 8'h7E;
    localparam logic [15:0] CRC_INIT  = 16'hFFFF;
    localparam logic [15:0] CRC_POLY  = 16'h8408;

    // Reflected CRC-16 update over one byte, LSB first.
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ d[i];
            r  = r >> 1;
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
    import hdlc_tx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr,
    input  entry_t wr_entry,
    input  logic   pop,
    output entry_t head,
    output logic   empty,
    output logic   full
);
    localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CMAX = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    entry_t   mem_q [DEPTH];
    logic     push, take;

    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CMAX);
    assign push  = wr && !full;
    assign take  = pop && !empty;
    assign head  = mem_q[s_q.rp];

    always_comb begin
        s_d = s_q;
        if (push) s_d.wp = (s_q.wp == LAST) ? '0 : s_q.wp + 1'b1;
        if (take) s_d.rp = (s_q.rp == LAST) ? '0 : s_q.rp + 1'b1;
        if (push && !take)      s_d.cnt = s_q.cnt + 1'b1;
        else if (take && !push) s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[s_q.wp] <= wr_entry;
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CMAX); // R11
    AST_FULL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && full && !pop) |=> full && $stable(s_q.wp)); // R11

endmodule

// File: rtl/hdlc_tx_engine.sv
module hdlc_tx_engine
    import hdlc_tx_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  logic   fill_sel,
    input  entry_t head,
    input  logic   empty,
    output logic   pop,
    output logic   tx_bit,
    output logic   underrun
);
    typedef struct packed {
        unit_e       kind;
        logic [7:0]  sh;
        logic [3:0]  cnt;
        logic        stuff;
        logic [2:0]  ones;
        logic        eop;
        logic [15:0] crc;
        logic        tx;
        logic        urun;
    } eng_st_t;

    eng_st_t s_d, s_q;
    logic    done;

    assign done = (s_q.cnt == '0) && !(s_q.stuff && s_q.ones == 3'd5);

    always_comb begin
        s_d      = s_q;
        s_d.urun = 1'b0;
        pop      = 1'b0;
        if (done) begin
            s_d.cnt = 4'd8;
            case (s_q.kind)
                U_OPEN, U_DATA: begin
                    if (s_q.kind == U_DATA && s_q.eop) begin
                        s_d.kind  = U_FCSL;
                        s_d.sh    = ~s_q.crc[7:0];
                        s_d.stuff = 1'b1;
                    end else if (empty) begin
                        s_d.kind  = U_ABORT;
                        s_d.sh    = 8'hFF;
                        s_d.stuff = 1'b0;
                        s_d.urun  = 1'b1;
                    end else begin
                        pop = 1'b1;
                        if (head.abort) begin
                            s_d.kind  = U_ABORT;
                            s_d.sh    = 8'hFF;
                            s_d.stuff = 1'b0;
                        end else begin
                            s_d.kind  = U_DATA;
                            s_d.sh    = head.data;
                            s_d.stuff = 1'b1;
                            s_d.eop   = head.eop;
                            s_d.crc   = crc_step((s_q.kind == U_OPEN) ? CRC_INIT : s_q.crc,
                                                 head.data);
                        end
                    end
                end
                U_FCSL: begin
                    s_d.kind = U_FCSH;
                    s_d.sh   = ~s_q.crc[15:8];
                end
                U_FCSH: begin
                    s_d.kind  = U_CLOSE;
                    s_d.sh    = FLAG_BYTE;
                    s_d.stuff = 1'b0;
                end
                default: begin
                    s_d.stuff = 1'b0;
                    s_d.eop   = 1'b0;
                    if (!en) begin
                        s_d.kind = U_OFF;
                        s_d.cnt  = '0;
                    end else if (!empty) begin
                        s_d.kind = U_OPEN;
                        s_d.sh   = FLAG_BYTE;
                    end else begin
                        s_d.kind = U_IDLE;
                        s_d.sh   = fill_sel ? FLAG_BYTE : 8'hFF;
                    end
                end
            endcase
            if (!s_d.stuff) s_d.ones = '0;
        end
        // emit one line bit
        if (s_d.kind == U_OFF) begin
            s_d.tx = 1'b1;
        end else if (s_d.stuff && s_d.ones == 3'd5) begin
            s_d.tx   = 1'b0;
            s_d.ones = '0;
        end else begin
            s_d.tx   = s_d.sh[0];
            s_d.sh   = s_d.sh >> 1;
            s_d.cnt  = s_d.cnt - 4'd1;
            s_d.ones = (s_d.stuff && s_d.sh[7] == 1'b0 && s_d.tx) ? s_d.ones + 3'd1 : 3'd0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.kind <= U_OFF;
            s_q.crc  <= CRC_INIT;
            s_q.tx   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_bit   = s_q.tx;
    assign underrun = s_q.urun;

    AST_STUFF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.stuff |-> s_q.ones <= 3'd5); // R7
    AST_OFF_IS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.kind == U_OFF && !en) |=> tx_bit); // R2
    AST_NO_CUT_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.kind inside {U_OPEN, U_DATA, U_FCSL, U_FCSH}) |=> s_q.kind != U_OFF); // R3
    AST_FCS_FOLLOWS_EOP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && s_q.kind == U_DATA && s_q.eop) |=> s_q.kind == U_FCSL); // R6
    AST_URUN_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> s_q.kind == U_ABORT); // R10

endmodule

// File: rtl/hdlc_tx_tagged.sv
module hdlc_tx_tagged
    import hdlc_tx_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       fill_sel,
    input  logic       arm_eop,
    input  logic       arm_abort,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic       fifo_full,
    output logic       eop_armed,
    output logic       abort_armed,
    output logic       tx_bit,
    output logic       underrun
);
    typedef struct packed {
        logic eop;
        logic abort;
    } tag_st_t;

    tag_st_t tag_d, tag_q;
    entry_t  wr_entry, head;
    logic    empty, pop, accept;

    assign accept = wr_en && !fifo_full;

    always_comb begin
        wr_entry.data  = wr_data;
        wr_entry.eop   = tag_q.eop   || arm_eop;
        wr_entry.abort = tag_q.abort || arm_abort;
        tag_d.eop      = accept ? 1'b0 : wr_entry.eop;
        tag_d.abort    = accept ? 1'b0 : wr_entry.abort;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tag_q <= '0;
        else        tag_q <= tag_d;
    end

    assign eop_armed   = tag_q.eop;
    assign abort_armed = tag_q.abort;

    hdlc_tx_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr_en),
        .wr_entry (wr_entry),
        .pop      (pop),
        .head     (head),
        .empty    (empty),
        .full     (fifo_full)
    );

    hdlc_tx_engine i_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (tx_en),
        .fill_sel (fill_sel),
        .head     (head),
        .empty    (empty),
        .pop      (pop),
        .tx_bit   (tx_bit),
        .underrun (underrun)
    );

    AST_TAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !eop_armed && !abort_armed); // R9
    AST_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (eop_armed && !wr_en) |=> eop_armed); // R9

endmodule

// File: tb/test_hdlc_tx_tagged.sv
module test_hdlc_tx_tagged;
    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, fill_sel = 1'b0, arm_eop = 1'b0, arm_abort = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       fifo_full, eop_armed, abort_armed, tx_bit, underrun;

    always #10 clk = ~clk; // 50 MHz

    hdlc_tx_tagged #(.DEPTH(DEPTH)) i_hdlc_tx_tagged (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fill_sel(fill_sel),
        .arm_eop(arm_eop), .arm_abort(arm_abort), .wr_en(wr_en), .wr_data(wr_data),
        .fifo_full(fifo_full), .eop_armed(eop_armed), .abort_armed(abort_armed),
        .tx_bit(tx_bit), .underrun(underrun)
    );

    int n_chk = 0, n_fail = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // ---------------- independent line receiver ----------------
    bit       bitbuf [512];
    int       bc = 0, ones = 0;
    bit       in_fr = 0;
    int       frame_cnt = 0, abort_cnt = 0, flag_cnt = 0, zero_cnt = 0, urun_cnt = 0;
    logic [7:0] rx [32];
    int       rx_len = 0;
    bit       rx_fcs_ok = 0;

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            r = (r[0] ^ d[i]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
        end
        return r;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (underrun) urun_cnt++;
            if (tx_bit) begin
                ones++;
                if (ones <= 5 && in_fr && bc < 512) begin bitbuf[bc] = 1; bc++; end
                if (ones == 7) begin
                    if (in_fr) abort_cnt++;
                    in_fr = 0;
                end
            end else begin
                zero_cnt++;
                if (ones == 6) begin
                    int len_b;
                    len_b = bc - 6;
                    if (in_fr && len_b >= 24 && len_b % 8 == 0) begin
                        int nb;
                        logic [15:0] c;
                        nb = len_b / 8;
                        for (int k = 0; k < nb && k < 32; k++)
                            for (int j = 0; j < 8; j++) rx[k][j] = bitbuf[k*8+j];
                        c = 16'hFFFF;
                        for (int k = 0; k < nb - 2; k++) c = ref_crc(c, rx[k]);
                        rx_len    = nb - 2;
                        rx_fcs_ok = ({rx[nb-1], rx[nb-2]} == ~c);
                        frame_cnt++;
                    end
                    flag_cnt++;
                    in_fr = 1;
                    bc = 0;
                end else if (ones != 5 && ones < 6 && in_fr && bc < 512) begin
                    bitbuf[bc] = 0; bc++;
                end
                ones = 0;
            end
        end
    end

    // ---------------- helpers ----------------
    logic [7:0] exp_b [32];
    int         exp_len = 0;

    task automatic put(input logic [7:0] d, input bit eop, input bit ab);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; arm_eop = eop; arm_abort = ab;
        @(negedge clk);
        wr_en = 1'b0; arm_eop = 1'b0; arm_abort = 1'b0;
    endtask

    task automatic wait_frames(input int target);
        for (int t = 0; t < 3000 && frame_cnt < target; t++) @(negedge clk);
    endtask

    task automatic check_frame(input string req);
        int bad = 0;
        for (int i = 0; i < exp_len; i++) if (rx[i] !== exp_b[i]) bad++;
        check(rx_len == exp_len, req, rx_len, exp_len);
        check(bad == 0 && rx_fcs_ok, req, bad, 0);
    endtask

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return seed[0] ? seed : seed + 8'(i * 29);
    endfunction

    // {fill_sel, length, seed}
    localparam logic [16:0] VECS [6] = '{
        {1'b0, 8'd1, 8'hFF}, {1'b1, 8'd4, 8'h7E}, {1'b0, 8'd8, 8'h10},
        {1'b1, 8'd3, 8'hFB}, {1'b0, 8'd2, 8'h00}, {1'b1, 8'd6, 8'hC2}
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R5: watchdog expired actual 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int f0, z0, a0, u0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(tx_bit == 1'b1, "R1 tx_bit", tx_bit, 1);
        check(!fifo_full && !eop_armed && !abort_armed, "R1 flags",
              {fifo_full, eop_armed, abort_armed}, 0);

        // R11 fill queue while disabled, ninth write dropped
        for (int i = 0; i < DEPTH; i++) begin
            exp_b[i] = 8'(8'h31 + i);
            put(exp_b[i], i == DEPTH - 1, 1'b0);
        end
        exp_len = DEPTH;
        check(fifo_full == 1'b1, "R11 full", fifo_full, 1);
        put(8'hEE, 1'b0, 1'b0);
        z0 = zero_cnt;
        repeat (50) @(negedge clk);
        check(zero_cnt == z0 && frame_cnt == 0, "R2 held while disabled", zero_cnt - z0, 0);
        tx_en = 1'b1;
        wait_frames(1);
        check(frame_cnt == 1, "R2 start on enable", frame_cnt, 1);
        check_frame("R11 eight entries");
        repeat (200) @(negedge clk);
        check(frame_cnt == 1, "R11 dropped write not sent", frame_cnt, 1);

        // vector table: R5 R6 R7 R4
        foreach (VECS[v]) begin
            fill_sel = VECS[v][16];
            exp_len  = int'(VECS[v][15:8]);
            f0 = frame_cnt;
            for (int i = 0; i < exp_len; i++) begin
                exp_b[i] = pat(VECS[v][7:0], i);
                put(exp_b[i], i == exp_len - 1, 1'b0);
            end
            wait_frames(f0 + 1);
            check(frame_cnt == f0 + 1, "R5 frame count", frame_cnt, f0 + 1);
            check_frame("R6 R7 frame content");
            repeat (20) @(negedge clk);
            z0 = zero_cnt; a0 = flag_cnt;
            repeat (40) @(negedge clk);
            if (fill_sel) check(flag_cnt - a0 >= 4, "R4 flag fill", flag_cnt - a0, 5);
            else          check(zero_cnt == z0, "R4 mark idle", zero_cnt - z0, 0);
        end

        // R5 two packets queued back to back
        fill_sel = 1'b0;
        f0 = frame_cnt;
        put(8'hA1, 1'b0, 1'b0); put(8'hA2, 1'b1, 1'b0);
        put(8'hB1, 1'b1, 1'b0);
        wait_frames(f0 + 2);
        check(frame_cnt == f0 + 2, "R5 two queued packets", frame_cnt, f0 + 2);
        exp_len = 1; exp_b[0] = 8'hB1;
        check_frame("R5 second packet");

        // R8 abort tag, then a good packet
        repeat (30) @(negedge clk);
        f0 = frame_cnt; a0 = abort_cnt;
        put(8'h11, 1'b0, 1'b0); put(8'h22, 1'b0, 1'b0); put(8'h33, 1'b0, 1'b1);
        put(8'h44, 1'b1, 1'b0);
        wait_frames(f0 + 1);
        check(abort_cnt == a0 + 1, "R8 abort seen", abort_cnt, a0 + 1);
        check(frame_cnt == f0 + 1, "R8 no frame for aborted packet", frame_cnt, f0 + 1);
        exp_len = 1; exp_b[0] = 8'h44;
        check_frame("R8 following packet");

        // R10 underrun
        repeat (30) @(negedge clk);
        a0 = abort_cnt; u0 = urun_cnt; f0 = frame_cnt;
        put(8'h55, 1'b0, 1'b0); put(8'h66, 1'b0, 1'b0);
        repeat (200) @(negedge clk);
        check(urun_cnt == u0 + 1, "R10 underrun pulse", urun_cnt - u0, 1);
        check(abort_cnt == a0 + 1 && frame_cnt == f0, "R10 packet aborted", abort_cnt - a0, 1);

        // R3 disable mid-packet
        f0 = frame_cnt;
        exp_len = 6;
        for (int i = 0; i < 6; i++) begin
            exp_b[i] = 8'(8'h90 + i * 3);
            put(exp_b[i], i == 5, 1'b0);
        end
        repeat (10) @(negedge clk);
        tx_en = 1'b0;
        wait_frames(f0 + 1);
        check(frame_cnt == f0 + 1, "R3 packet completes", frame_cnt, f0 + 1);
        check_frame("R3 packet content");

        // R9 one-shot tag, R2 hold while off
        repeat (20) @(negedge clk);
        @(negedge clk); arm_eop = 1'b1;
        @(negedge clk); arm_eop = 1'b0;
        check(eop_armed == 1'b1, "R9 tag armed", eop_armed, 1);
        f0 = frame_cnt; z0 = zero_cnt;
        put(8'h5A, 1'b0, 1'b0);
        check(eop_armed == 1'b0, "R9 tag self-clears", eop_armed, 0);
        repeat (100) @(negedge clk);
        check(zero_cnt == z0 && frame_cnt == f0, "R2 idle line while off", zero_cnt - z0, 0);
        tx_en = 1'b1;
        wait_frames(f0 + 1);
        exp_len = 1; exp_b[0] = 8'h5A;
        check(frame_cnt == f0 + 1, "R9 tag carried to write", frame_cnt, f0 + 1);
        check_frame("R9 packet content");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule